// File: doc/BRIEF.md
# Look-Ahead Carry Arithmetic/Logic Unit

A purely combinational, parameter-width arithmetic/logic unit (8 bits by default) that is assembled from identical single-bit slices. Each slice produces a generate and a propagate term for its bit. A binary tree of two-input look-ahead generators merges neighbouring units into groups of 2, 4 and 8 bits. Each generator hands back the carry into its upper half together with the generate and propagate terms of the group. As a result, every internal carry arrives after a logarithmic number of gate levels rather than rippling through the slices.

A 3-bit operation code picks one of eight functions:
- add with carry-in;
- b minus a, formed by feeding the inverted a operand into the adder;
- three bitwise logic operations;
- single-position shifts of b with serial fill inputs;
- a forced zero result.

The shifts need no logic beyond rewiring of the b operand. Four status flags (carry, zero, sign and overflow) accompany the result. The internal bit carries are also brought out, so that the look-ahead tree can be observed directly.

Top module: `alu_lca`

## Requirements
- R1: Operation code 0 (add) gives f = (a + b + ci) mod 256.
- R2: Operation code 1 (subtract) gives f = (~a + b + ci) mod 256. This equals b − a when ci = 1; ci = 0 borrows one more.
- R3: Operation codes 2, 3 and 4 give a AND b, a OR b and a XOR b respectively.
- R4: Operation code 5 gives f = {b[6:0], sl_i}. The output sl_o always equals b[7], whatever the operation code.
- R5: Operation code 6 gives f = {sr_i, b[7:1]}. The output sr_o always equals b[0], whatever the operation code.
- R6: Operation code 7 gives f = 0 for every operand and fill value.
- R7: cf_o is the adder carry out of bit 7 for codes 0 and 1. It is 0 for codes 2 to 7.
- R8: vf_o is 1 exactly when the carry into bit 7 differs from the carry out of bit 7, for codes 0 and 1. It is 0 for codes 2 to 7.
- R9: zf_o is 1 exactly when f is 0, and sf_o equals f[7], for every operation code.
- R10: icarry_o[k-1], for k = 1..7, is the carry into bit k of the sum x + b + ci. Here x is ~a for code 1 and a for every other code. Each of these carries reaches 1 for some input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | Operand a (the subtrahend when subtracting) |
| b_i | input | 8 | Operand b (the operand that is shifted) |
| fsel_i | input | 3 | Operation code |
| ci_i | input | 1 | Carry-in / borrow input |
| sl_i | input | 1 | Fill bit for the LSB on a left shift |
| sr_i | input | 1 | Fill bit for the MSB on a right shift |
| f_o | output | 8 | Result |
| sl_o | output | 1 | Bit shifted out on a left shift (b[7]) |
| sr_o | output | 1 | Bit shifted out on a right shift (b[0]) |
| cf_o | output | 1 | Carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| vf_o | output | 1 | Two's-complement overflow flag |
| icarry_o | output | 7 | Internal carries into bits 1..7 |

## Verification
The carry tree and the shift-out wiring stay live under every operation code. In any single cycle, an arithmetic result with its carry and overflow flags therefore coexists with valid shift-out bits. Likewise, the exposed carries keep moving while a logic or shift result is selected.

The sweep applies all 256 a values against a spread of b values, both carry-in values and every operation code, with the fill bits varied. Each vector is judged against arithmetic references for the result, flags, shift-outs and every internal carry. Explicit cases cover 0x7F+0x01, 0xFF+0x01 and 0x9F−0x15, and each internal carry is required to have been 1 at least once.

// File: rtl/alu_lca_pkg.sv
package alu_lca_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SHL = 3'd5,
    OP_SHR = 3'd6,
    OP_CLR = 3'd7
  } alu_op_e;

  function automatic logic op_is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_lca_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    c_i,
  input  logic    lo_fill_i,
  input  logic    hi_fill_i,
  input  alu_op_e op_i,
  output logic    g_o,
  output logic    p_o,
  output logic    f_o
);
  logic a_eff;

  assign a_eff = (op_i == OP_SUB) ? ~a_i : a_i;
  assign g_o   = a_eff & b_i;
  assign p_o   = a_eff ^ b_i;

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_SUB: f_o = p_o ^ c_i;
      OP_AND:         f_o = a_i & b_i;
      OP_OR:          f_o = a_i | b_i;
      OP_XOR:         f_o = a_i ^ b_i;
      OP_SHL:         f_o = lo_fill_i;
      OP_SHR:         f_o = hi_fill_i;
      default:        f_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_lca_gen.sv
module alu_lca_gen (
  input  logic g_lo_i,
  input  logic p_lo_i,
  input  logic g_hi_i,
  input  logic p_hi_i,
  input  logic c_i,
  output logic c_mid_o,
  output logic g_o,
  output logic p_o
);
  assign c_mid_o = g_lo_i | (p_lo_i & c_i);
  assign g_o     = g_hi_i | (p_hi_i & g_lo_i);
  assign p_o     = p_hi_i & p_lo_i;
endmodule

// File: rtl/alu_lca_tree.sv
// Heap-indexed tree: node 1 is the root, leaves N..2N-1 map to bits 0..N-1.
module alu_lca_tree #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  input  logic         c_i,
  output logic [N-1:0] c_bit_o,
  output logic         c_out_o
);
  localparam int unsigned NODES = 2 * N;

  logic [NODES-1:1] g_n;
  logic [NODES-1:1] p_n;
  logic [NODES-1:1] c_n;

  assign c_n[1] = c_i;

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign g_n[N+i]   = g_i[i];
    assign p_n[N+i]   = p_i[i];
    assign c_bit_o[i] = c_n[N+i];
  end

  for (genvar k = 1; k < N; k++) begin : g_node
    assign c_n[2*k] = c_n[k];
    alu_lca_gen u_gen (
      .g_lo_i (g_n[2*k]),
      .p_lo_i (p_n[2*k]),
      .g_hi_i (g_n[2*k+1]),
      .p_hi_i (p_n[2*k+1]),
      .c_i    (c_n[k]),
      .c_mid_o(c_n[2*k+1]),
      .g_o    (g_n[k]),
      .p_o    (p_n[k])
    );
  end

  assign c_out_o = g_n[1] | (p_n[1] & c_i);
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_lca_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] f_i,
  input  logic         c_msb_i,
  input  logic         c_out_i,
  input  alu_op_e      op_i,
  output logic         cf_o,
  output logic         zf_o,
  output logic         sf_o,
  output logic         vf_o
);
  logic arith;

  assign arith = op_is_arith(op_i);
  assign cf_o  = arith & c_out_i;
  assign vf_o  = arith & (c_msb_i ^ c_out_i);
  assign zf_o  = ~|f_i;
  assign sf_o  = f_i[W-1];
endmodule

// File: rtl/alu_lca.sv
module alu_lca
  import alu_lca_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   fsel_i,
  input  logic         ci_i,
  input  logic         sl_i,
  input  logic         sr_i,
  output logic [W-1:0] f_o,
  output logic         sl_o,
  output logic         sr_o,
  output logic         cf_o,
  output logic         zf_o,
  output logic         sf_o,
  output logic         vf_o,
  output logic [W-2:0] icarry_o
);
  alu_op_e      op;
  logic [W-1:0] g, p, c_bit;
  logic         c_out;

  assign op = alu_op_e'(fsel_i);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic lo_fill, hi_fill;
    if (i == 0) begin : g_lsb
      assign lo_fill = sl_i;
    end else begin : g_lo
      assign lo_fill = b_i[i-1];
    end
    if (i == W - 1) begin : g_msb
      assign hi_fill = sr_i;
    end else begin : g_hi
      assign hi_fill = b_i[i+1];
    end
    alu_slice u_slice (
      .a_i      (a_i[i]),
      .b_i      (b_i[i]),
      .c_i      (c_bit[i]),
      .lo_fill_i(lo_fill),
      .hi_fill_i(hi_fill),
      .op_i     (op),
      .g_o      (g[i]),
      .p_o      (p[i]),
      .f_o      (f_o[i])
    );
  end

  alu_lca_tree #(.N(W)) u_tree (
    .g_i    (g),
    .p_i    (p),
    .c_i    (ci_i),
    .c_bit_o(c_bit),
    .c_out_o(c_out)
  );

  alu_flags #(.W(W)) u_flags (
    .f_i    (f_o),
    .c_msb_i(c_bit[W-1]),
    .c_out_i(c_out),
    .op_i   (op),
    .cf_o   (cf_o),
    .zf_o   (zf_o),
    .sf_o   (sf_o),
    .vf_o   (vf_o)
  );

  assign sl_o     = b_i[W-1];
  assign sr_o     = b_i[0];
  assign icarry_o = c_bit[W-1:1];
endmodule

// File: rtl/alu_lca_chk.sv
module alu_lca_chk #(
  parameter int unsigned W = 8
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [2:0]   fsel_i,
  input logic         ci_i,
  input logic         sl_i,
  input logic         sr_i,
  input logic [W-1:0] f_o,
  input logic         sl_o,
  input logic         sr_o,
  input logic         cf_o,
  input logic         zf_o,
  input logic         sf_o,
  input logic         vf_o,
  input logic [W-2:0] icarry_o
);
  logic [W:0] add_ref;

  assign add_ref = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci_i};

  always_comb begin
    AST_ADD_RESULT: assert (fsel_i != 3'd0 || {cf_o, f_o} == add_ref); // R1
    AST_CLEAR: assert (fsel_i != 3'd7 || f_o == '0); // R6
    AST_SHIFT_OUTS: assert (sl_o == b_i[W-1] && sr_o == b_i[0]); // R4
    AST_NO_ARITH_FLAGS: assert (fsel_i < 3'd2 || (!cf_o && !vf_o)); // R7
    AST_ZERO_SIGN: assert (zf_o == (f_o == '0) && sf_o == f_o[W-1]); // R9
    AST_SHL_FILL: assert (fsel_i != 3'd5 || f_o[0] == sl_i); // R4
    AST_SHR_FILL: assert (fsel_i != 3'd6 || f_o[W-1] == sr_i); // R5
  end
endmodule

bind alu_lca alu_lca_chk #(.W(W)) u_chk (.*);

// File: tb/tb_alu_lca.sv
module tb_alu_lca;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] a, b, f;
  logic [2:0] fsel;
  logic       ci, sli, sri, slo, sro, cf, zf, sf, vf;
  logic [6:0] icarry, seen_c;
  int         n_chk = 0, n_bad = 0;

  alu_lca dut (
    .a_i(a), .b_i(b), .fsel_i(fsel), .ci_i(ci), .sl_i(sli), .sr_i(sri),
    .f_o(f), .sl_o(slo), .sr_o(sro), .cf_o(cf), .zf_o(zf), .sf_o(sf),
    .vf_o(vf), .icarry_o(icarry)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s a=%02h b=%02h fsel=%0d ci=%0d act=%0h exp=%0h",
               req, a, b, fsel, ci, act, exp);
    end
  endtask

  task automatic apply_and_check();
    logic [7:0] x, ef;
    logic [8:0] s;
    logic [6:0] ec;
    logic       ecf, evf, arith;
    string      rq;
    @(posedge clk);
    x = (fsel == 3'd1) ? ~a : a;
    s = {1'b0, x} + {1'b0, b} + {8'd0, ci};
    for (int k = 1; k < 8; k++) begin
      logic [8:0] m, part;
      m = (9'd1 << k) - 9'd1;
      part = ({1'b0, x} & m) + ({1'b0, b} & m) + {8'd0, ci};
      ec[k-1] = part[k];
    end
    arith = (fsel < 3'd2);
    case (fsel)
      3'd0: begin ef = s[7:0]; rq = "R1"; end
      3'd1: begin ef = s[7:0]; rq = "R2"; end
      3'd2: begin ef = a & b; rq = "R3"; end
      3'd3: begin ef = a | b; rq = "R3"; end
      3'd4: begin ef = a ^ b; rq = "R3"; end
      3'd5: begin ef = {b[6:0], sli}; rq = "R4"; end
      3'd6: begin ef = {sri, b[7:1]}; rq = "R5"; end
      default: begin ef = 8'd0; rq = "R6"; end
    endcase
    ecf = arith & s[8];
    evf = arith & (s[8] ^ ec[6]);
    @(negedge clk);
    chk(f == ef, rq, f, ef);
    chk(cf == ecf, "R7", cf, ecf);
    chk(vf == evf, "R8", vf, evf);
    chk(zf == (ef == 8'd0) && sf == ef[7], "R9", {zf, sf}, {ef == 8'd0, ef[7]});
    chk(slo == b[7] && sro == b[0], "R4/R5 shift-out", {slo, sro}, {b[7], b[0]});
    chk(icarry == ec, "R10", icarry, ec);
    seen_c |= icarry;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    seen_c = '0;
    a = 8'd0; b = 8'd0; fsel = 3'd0; ci = 1'b0; sli = 1'b0; sri = 1'b0;
    // quiescent: all-zero inputs give a zero result with zero flag set
    apply_and_check();

    // R2 example: b=9F minus a=15 with no borrow -> 8A, carry set
    a = 8'h15; b = 8'h9F; fsel = 3'd1; ci = 1'b1; apply_and_check();
    chk(f == 8'h8A && cf && !vf && sf, "R2 9F-15", {f, cf, vf}, {8'h8A, 3'b100});
    // R8: 7F+01 overflows
    a = 8'h7F; b = 8'h01; fsel = 3'd0; ci = 1'b0; apply_and_check();
    chk(f == 8'h80 && vf && !cf, "R8 7F+01", {f, cf, vf}, {8'h80, 2'b01});
    // R7: FF+01 carries out with zero result
    a = 8'hFF; b = 8'h01; apply_and_check();
    chk(f == 8'h00 && cf && zf && !vf, "R7 FF+01", {f, cf, zf, vf}, {8'h00, 3'b110});
    // R6 with every fill bit high
    a = 8'hFF; b = 8'hFF; fsel = 3'd7; ci = 1'b1; sli = 1'b1; sri = 1'b1; apply_and_check();

    for (int op = 0; op < 8; op++)
      for (int c = 0; c < 2; c++)
        for (int j = 0; j < 24; j++)
          for (int ai = 0; ai < 256; ai++) begin
            fsel = 3'(op); ci = c[0];
            b = 8'(j * 11 + ((j == 23) ? 2 : 0));
            a = 8'(ai);
            sli = a[0] ^ j[0];
            sri = a[1] ^ j[1];
            apply_and_check();
          end

    chk(seen_c == 7'h7F, "R10 every carry seen high", seen_c, 7'h7F);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule